// File: doc/BRIEF.md
# Keyed Watchdog and Reset Generator

This block combines a watchdog counter, a chip-reset pulse generator and a record of why the last reset happened. Software starts the watchdog by writing an ordered pair of key words to a control register. A second ordered pair stops it. Reading the same register returns the live count. While the watchdog runs, the count drops by one on every reference-clock tick. When it reaches zero the block raises a one-cycle expiry event and starts a chip-reset pulse. The pulse length, in ticks, is programmable.

Software can also ask for a chip reset through a software-reset register. That request uses the same pulse length. A one-hot status register holds the cause of the latest reset: power-on, hardware (watchdog expiry or the external request), software, or PCIe. The block itself is reset only by the power-on input. The reset pulse it drives goes to a distribution network outside the block.

Register offsets: default count 0x28, control and live count 0x2C, pulse length 0x30, software reset 0x34, reset cause 0x38. Read data follows the bus address combinationally. Writes take effect at the clock edge on which select and write are both high.

Top module: `wdog_rstgen`

## Requirements
- R1: While `por_n` is low, and after it rises, the block holds these values. Offset 0x38 reads 0x80000000. Offset 0x2C and offset 0x28 both read the DFLT_INIT parameter. Offset 0x30 reads PLEN_INIT. `chip_rst` and `wd_expire_evt` are low, and the watchdog is stopped.
- R2: The watchdog starts when 0x0000FF00 and then 0x000000FF are written to 0x2C as two consecutive writes to that offset. From the clock edge after the second write, the count read at 0x2C drops by one per cycle.
- R3: Writing 0x0000EE00 and then 0x000000EE to 0x2C as consecutive writes to that offset stops the watchdog. The same write loads the count from offset 0x28, and the count then holds.
- R4: A key pair completes only if its second word is the very next write to 0x2C. Any other value written to 0x2C in between cancels the pair, and so does the pair written in the wrong order. Writes to other offsets do not affect the pair.
- R5: During the cycle in which a running count reads zero, `wd_expire_evt` is high for exactly that one cycle. At the next edge the count reloads from 0x28 and the watchdog stops.
- R6: `chip_rst` rises in the cycle after an expiry event. It stays high for exactly N cycles, where N is the value at 0x30; a value of 0 gives one cycle.
- R7: Writing a value with bit 0 set to 0x34 drives `chip_rst` from the next cycle for N cycles, with N as in R6. A write with bit 0 clear has no effect. Offset 0x34 reads 0.
- R8: Offset 0x38 holds exactly one cause bit in [31:28]: 31 power-on, 30 hardware (expiry or `hw_rst_req`), 29 software, 28 PCIe (`pcie_rst_req`). Bits 27:0 read 0. When causes coincide, hardware wins over software and software wins over PCIe. Writes to 0x38 are ignored.
- R9: A reset request that arrives while `chip_rst` is high does not lengthen the pulse. Its cause is still recorded.
- R10: Offsets 0x28 and 0x30 read back the last value written. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; one tick per cycle |
| por_n | input | 1 | Power-on indication, active low; resets the block |
| hw_rst_req | input | 1 | External hardware reset request (cause only) |
| pcie_rst_req | input | 1 | PCIe reset indication (cause only) |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| wd_expire_evt | output | 1 | One-cycle watchdog expiry event |
| chip_rst | output | 1 | Chip reset pulse, active high |

## Verification
The assertions assume at most one register write per cycle. They also assume that no stop pair completes on the same edge as an expiry. The stimulus keeps to both: every access goes through a task that issues one write and then idles. The random phase loads a default count far larger than its own run length, so key writes never meet an expiry. Writes that must coincide with a request input are directed, with the timing chosen by hand.

// File: rtl/wdog_rstgen.sv
module wdog_rstgen #(
  parameter int ADDR_W = 8,
  parameter int CNT_W = 32,
  parameter int LEN_W = 32,
  parameter logic [CNT_W-1:0] DFLT_INIT = 'h00FF_FFFF,
  parameter logic [LEN_W-1:0] PLEN_INIT = 'd50
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              hw_rst_req,
  input  logic              pcie_rst_req,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              wd_expire_evt,
  output logic              chip_rst
);
  localparam logic [ADDR_W-1:0] OFS_DFLT = ADDR_W'(8'h28);
  localparam logic [ADDR_W-1:0] OFS_CTL  = ADDR_W'(8'h2C);
  localparam logic [ADDR_W-1:0] OFS_PLEN = ADDR_W'(8'h30);
  localparam logic [ADDR_W-1:0] OFS_SWR  = ADDR_W'(8'h34);
  localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'(8'h38);
  localparam logic [31:0] GO_A   = 32'h0000_FF00;
  localparam logic [31:0] GO_B   = 32'h0000_00FF;
  localparam logic [31:0] HALT_A = 32'h0000_EE00;
  localparam logic [31:0] HALT_B = 32'h0000_00EE;

  typedef enum logic [1:0] {K_IDLE, K_GO, K_HALT} key_t;

  key_t             key;
  logic             running;
  logic [CNT_W-1:0] cnt, dflt;
  logic [LEN_W-1:0] plen, pulse_cnt;
  logic [3:0]       status;

  logic wr_any, wr_ctl, start_done, stop_done, expire, sw_req, hw_evt, pulse_req;
  logic [LEN_W-1:0] plen_eff;

  assign wr_any     = bus_sel & bus_wr;
  assign wr_ctl     = wr_any && (bus_addr == OFS_CTL);
  assign start_done = wr_ctl && (key == K_GO) && (bus_wdata == GO_B);
  assign stop_done  = wr_ctl && (key == K_HALT) && (bus_wdata == HALT_B);
  assign expire     = running && (cnt == '0);
  assign sw_req     = wr_any && (bus_addr == OFS_SWR) && bus_wdata[0];
  assign hw_evt     = expire | hw_rst_req;
  assign pulse_req  = expire | sw_req;
  assign plen_eff   = (plen == '0) ? LEN_W'(1) : plen;

  assign wd_expire_evt = expire;
  assign chip_rst      = (pulse_cnt != '0);

  always_ff @(posedge clk) begin
    if (!por_n) key <= K_IDLE;
    else if (wr_ctl) begin
      if (bus_wdata == GO_A)        key <= K_GO;
      else if (bus_wdata == HALT_A) key <= K_HALT;
      else                          key <= K_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!por_n) begin
      cnt     <= DFLT_INIT;
      running <= 1'b0;
    end else if (stop_done || expire) begin
      cnt     <= dflt;
      running <= 1'b0;
    end else begin
      if (start_done) running <= 1'b1;
      if (running)    cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!por_n) begin
      dflt <= DFLT_INIT;
      plen <= PLEN_INIT;
    end else begin
      if (wr_any && bus_addr == OFS_DFLT) dflt <= bus_wdata[CNT_W-1:0];
      if (wr_any && bus_addr == OFS_PLEN) plen <= bus_wdata[LEN_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!por_n)                     pulse_cnt <= '0;
    else if (pulse_req && !chip_rst) pulse_cnt <= plen_eff;
    else if (chip_rst)               pulse_cnt <= pulse_cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!por_n)            status <= 4'b1000;
    else if (hw_evt)       status <= 4'b0100;
    else if (sw_req)       status <= 4'b0010;
    else if (pcie_rst_req) status <= 4'b0001;
  end

  always_comb begin
    case (bus_addr)
      OFS_CTL:  bus_rdata = 32'(cnt);
      OFS_DFLT: bus_rdata = 32'(dflt);
      OFS_PLEN: bus_rdata = 32'(plen);
      OFS_STAT: bus_rdata = {status, 28'b0};
      default:  bus_rdata = 32'b0;
    endcase
  end
endmodule

// File: rtl/wdog_rstgen_chk.sv
module wdog_rstgen_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             por_n,
  input logic             evt,
  input logic             rst_out,
  input logic             run,
  input logic [CNT_W-1:0] cnt,
  input logic             ctl_wr,
  input logic [3:0]       status
);
  // R5
  expire_single_chk: assert property (@(posedge clk) disable iff (!por_n)
    evt |=> !evt);

  // R5
  expire_stops_chk: assert property (@(posedge clk) disable iff (!por_n)
    evt |=> !run);

  // R6
  expire_pulse_chk: assert property (@(posedge clk) disable iff (!por_n)
    (evt && !rst_out) |=> rst_out);

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!por_n)
    (run && cnt != '0 && !ctl_wr) |=> (cnt == CNT_W'($past(cnt) - 1'b1)));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    (!run && !ctl_wr) |=> $stable(cnt));

  // R8
  cause_onehot_chk: assert property (@(posedge clk) disable iff (!por_n)
    $countones(status) == 1);
endmodule

bind wdog_rstgen wdog_rstgen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .por_n(por_n), .evt(wd_expire_evt), .rst_out(chip_rst),
  .run(running), .cnt(cnt), .ctl_wr(wr_ctl), .status(status)
);

// File: tb/wdog_rstgen_tb.sv
module wdog_rstgen_tb;
  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic hw_rst_req = 1'b0, pcie_rst_req = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_addr = 8'h2C;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic wd_expire_evt, chip_rst;

  int tests = 0, fails = 0, hi_cnt = 0;
  bit done = 0;

  always #10 clk = ~clk;

  wdog_rstgen #(.DFLT_INIT(32'd1000), .PLEN_INIT(32'd4)) u_dut (
    .clk(clk), .por_n(por_n), .hw_rst_req(hw_rst_req), .pcie_rst_req(pcie_rst_req),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .wd_expire_evt(wd_expire_evt), .chip_rst(chip_rst));

  always @(negedge clk) if (chip_rst) hi_cnt++;

  // Reference model of the watchdog count
  int m_key = 0;
  logic [31:0] m_cnt = 32'd1000, m_dflt = 32'd1000;
  bit m_run = 0;
  always @(posedge clk) begin
    bit wc, st, sd, ex;
    if (!por_n) begin
      m_cnt = 32'd1000; m_dflt = 32'd1000; m_run = 0; m_key = 0;
    end else begin
      wc = bus_sel && bus_wr && bus_addr == 8'h2C;
      st = wc && m_key == 1 && bus_wdata == 32'h00FF;
      sd = wc && m_key == 2 && bus_wdata == 32'h00EE;
      ex = m_run && m_cnt == 0;
      if (sd || ex) begin m_cnt = m_dflt; m_run = 0; end
      else begin
        if (m_run) m_cnt = m_cnt - 1;
        if (st) m_run = 1;
      end
      if (wc) m_key = (bus_wdata == 32'hFF00) ? 1 : (bus_wdata == 32'hEE00) ? 2 : 0;
      if (bus_sel && bus_wr && bus_addr == 8'h28) m_dflt = bus_wdata;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; bus_addr = 8'h2C;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; #1 d = bus_rdata; bus_addr = 8'h2C;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=%h expected=%h", 32'd0, 32'd1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int k;
    idle(5);
    rd(8'h38, d); chk("R1 status in reset", d, 32'h8000_0000);
    por_n = 1;
    @(negedge clk);
    rd(8'h38, d); chk("R1 status", d, 32'h8000_0000);
    rd(8'h2C, d); chk("R1 count", d, 32'd1000);
    rd(8'h28, d); chk("R1 default", d, 32'd1000);
    rd(8'h30, d); chk("R1 length", d, 32'd4);
    chk("R1 chip_rst", {31'b0, chip_rst}, 32'd0);
    idle(3);
    rd(8'h2C, d); chk("R1 stopped", d, 32'd1000);
    chk("R1 evt", {31'b0, wd_expire_evt}, 32'd0);

    // R10 readback and unmapped offsets
    wr(8'h28, 32'd20); wr(8'h30, 32'd5);
    rd(8'h28, d); chk("R10 default rb", d, 32'd20);
    rd(8'h30, d); chk("R10 length rb", d, 32'd5);
    rd(8'h3C, d); chk("R10 unmapped", d, 32'd0);
    rd(8'h00, d); chk("R10 unmapped0", d, 32'd0);

    // R3 stop pair reloads
    wr(8'h2C, 32'hEE00); wr(8'h2C, 32'h00EE);
    rd(8'h2C, d); chk("R3 reload", d, 32'd20);

    // R2 start and count, R5 expiry, R6 pulse
    wr(8'h2C, 32'hFF00); wr(8'h2C, 32'h00FF);
    rd(8'h2C, d); chk("R2 start value", d, 32'd20);
    idle(3);
    rd(8'h2C, d); chk("R2 decrement", d, 32'd17);
    k = 3;
    while (!wd_expire_evt && k < 100) begin @(negedge clk); k++; end
    chk("R5 expiry cycle", k, 32'd20);
    rd(8'h2C, d); chk("R5 count zero at event", d, 32'd0);
    hi_cnt = 0;
    @(negedge clk);
    chk("R5 single cycle", {31'b0, wd_expire_evt}, 32'd0);
    chk("R6 pulse starts", {31'b0, chip_rst}, 32'd1);
    rd(8'h2C, d); chk("R5 reloaded", d, 32'd20);
    idle(10);
    chk("R6 pulse length", hi_cnt, 32'd5);
    rd(8'h2C, d); chk("R5 stopped after expiry", d, 32'd20);
    rd(8'h38, d); chk("R8 hw cause from expiry", d, 32'h4000_0000);

    // R7 software reset
    wr(8'h30, 32'd3);
    hi_cnt = 0;
    wr(8'h34, 32'd1);
    chk("R7 pulse starts", {31'b0, chip_rst}, 32'd1);
    idle(6);
    chk("R7 pulse length", hi_cnt, 32'd3);
    rd(8'h38, d); chk("R7 sw cause", d, 32'h2000_0000);
    rd(8'h34, d); chk("R7 reads zero", d, 32'd0);
    hw_rst_req = 1; @(negedge clk); hw_rst_req = 0;
    rd(8'h38, d); chk("R8 ext hw cause", d, 32'h4000_0000);
    hi_cnt = 0;
    wr(8'h34, 32'hFFFF_FFFE);
    idle(5);
    chk("R7 bit0 clear no pulse", hi_cnt, 32'd0);
    rd(8'h38, d); chk("R7 bit0 clear no cause", d, 32'h4000_0000);

    // R6 zero length
    wr(8'h30, 32'd0);
    hi_cnt = 0;
    wr(8'h34, 32'd1);
    idle(5);
    chk("R6 zero length gives one", hi_cnt, 32'd1);

    // R9 no extension
    wr(8'h30, 32'd6);
    hw_rst_req = 1; @(negedge clk); hw_rst_req = 0;
    hi_cnt = 0;
    wr(8'h34, 32'd1);
    @(negedge clk);
    wr(8'h34, 32'd1);
    idle(10);
    chk("R9 pulse not extended", hi_cnt, 32'd6);
    rd(8'h38, d); chk("R9 cause recorded", d, 32'h2000_0000);

    // R4 key sequencing
    wr(8'h2C, 32'hFF00); wr(8'h30, 32'd4); wr(8'h2C, 32'h00FF);
    idle(2);
    rd(8'h2C, d); chk("R4 other offset keeps pair", d, 32'd18);
    wr(8'h2C, 32'hEE00); wr(8'h2C, 32'h00EE);
    wr(8'h2C, 32'hFF00); wr(8'h2C, 32'h1234); wr(8'h2C, 32'h00FF);
    idle(3);
    rd(8'h2C, d); chk("R4 broken pair", d, 32'd20);
    wr(8'h2C, 32'h00FF); wr(8'h2C, 32'hFF00);
    idle(3);
    rd(8'h2C, d); chk("R4 reversed pair", d, 32'd20);
    wr(8'h2C, 32'hEE00); wr(8'h2C, 32'h1234); wr(8'h2C, 32'h00EE);
    rd(8'h2C, d); chk("R4 broken stop", d, 32'd20);

    // R8 cause priorities and write protection
    pcie_rst_req = 1; @(negedge clk); pcie_rst_req = 0;
    rd(8'h38, d); chk("R8 pcie cause", d, 32'h1000_0000);
    wr(8'h38, 32'hFFFF_FFFF);
    rd(8'h38, d); chk("R8 write ignored", d, 32'h1000_0000);
    pcie_rst_req = 1; wr(8'h34, 32'd1); pcie_rst_req = 0;
    rd(8'h38, d); chk("R8 sw over pcie", d, 32'h2000_0000);
    idle(8);
    hw_rst_req = 1; pcie_rst_req = 1; wr(8'h34, 32'd1);
    hw_rst_req = 0; pcie_rst_req = 0;
    rd(8'h38, d); chk("R8 hw wins", d, 32'h4000_0000);
    idle(8);

    // Random key traffic against the model (R2 R3 R4)
    void'($urandom(32'd4242));
    wr(8'h28, 32'd50000);
    wr(8'h2C, 32'hEE00); wr(8'h2C, 32'h00EE);
    for (int i = 0; i < 300; i++) begin
      int r;
      r = $urandom % 6;
      case (r)
        0: wr(8'h2C, 32'hFF00);
        1: wr(8'h2C, 32'h00FF);
        2: wr(8'h2C, 32'hEE00);
        3: wr(8'h2C, 32'h00EE);
        4: wr(8'h2C, $urandom & 32'h0000_FFFF);
        default: wr(8'h30, ($urandom % 8) + 1);
      endcase
      idle($urandom % 3);
      rd(8'h2C, d); chk("R4 random count", d, m_cnt);
      chk("R5 no expiry in random", {31'b0, wd_expire_evt}, 32'd0);
    end

    // R1 power-on again
    por_n = 0; idle(2); por_n = 1; @(negedge clk);
    rd(8'h38, d); chk("R1 por cause", d, 32'h8000_0000);
    rd(8'h2C, d); chk("R1 por count", d, 32'd1000);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule